// File: doc/BRIEF.md
# HDLC Frame Check Sequence Engine

This block computes the 16-bit HDLC frame check sequence for both directions of a serial link, one bit per clock. On the transmit side it runs over the address, control and information bits of a frame. It passes each bit through, then shifts out the complemented remainder as a 16-bit FCS. On the receive side it runs over every bit before the closing flag, including the received FCS. It forwards those bits unchanged and tests the final register against the fixed good-frame residue. The result is reported on two status outputs that hold until the next frame begins.

Bit stuffing, flag handling and frame delineation belong to the neighbouring framer. That framer marks each frame with a start strobe, qualifies each bit with a valid strobe and closes the frame with an end strobe. The end strobe is never raised together with a valid bit. A per-frame mode input selects between normal operation and a bypass in which no FCS is added or checked.

Top module: `hdlc_fcs_unit`

## Requirements
- R1: A start strobe presets the CRC register of its direction to all ones, so an empty transmit frame yields an FCS of 0x0000.
- R2: Bits are taken least significant bit first through the reflected form of x^16 + x^12 + x^5 + 1 (feedback constant 0x8408); the bytes of the ASCII string "123456789" yield the FCS 0x906E.
- R3: Each transmit data bit appears on `tx_out_bit` with `tx_out_valid` high one clock after it is presented.
- R4: In CRC mode, the ones' complement of the register is sent over 16 consecutive valid cycles, low-order bit first, starting the cycle after `tx_end`.
- R5: `tx_done` is a one-cycle pulse: in CRC mode it comes in the cycle after the final FCS bit, in no-CRC mode in the cycle after `tx_end`.
- R6: Every received bit, FCS bits included, is forwarded on `rx_fwd_bit` with `rx_fwd_valid` high one clock after it is presented.
- R7: On `rx_end` in CRC mode, `rx_frame_ok` is set if the register equals 0xF0B8 and `rx_crc_err` is set otherwise; the two are never high together.
- R8: A receive frame of fewer than 16 bits ends with `rx_crc_err` set.
- R9: Both status outputs keep their value until the next `rx_start`, which clears them in the following cycle.
- R10: In no-CRC mode (`crc_en` = 0) the transmitter sends no FCS bits and both receive status outputs stay low.
- R11: `crc_en` is sampled only on the start strobe of each direction; changing it during a frame has no effect on that frame.
- R12: After reset every output is low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| crc_en | input | 1 | 1 = CRC mode, 0 = no-CRC bypass; sampled on each start strobe |
| tx_start | input | 1 | Transmit frame start, presets the transmit register |
| tx_valid | input | 1 | Transmit data bit qualifier |
| tx_bit | input | 1 | Transmit data bit |
| tx_end | input | 1 | Transmit end of data; starts FCS emission in CRC mode |
| tx_out_valid | output | 1 | Outgoing bit qualifier (data or FCS) |
| tx_out_bit | output | 1 | Outgoing bit |
| tx_done | output | 1 | One-cycle pulse after the frame's last outgoing bit |
| rx_start | input | 1 | Receive frame start, presets register and clears status |
| rx_valid | input | 1 | Receive bit qualifier |
| rx_bit | input | 1 | Receive bit (data and FCS) |
| rx_end | input | 1 | Receive end of frame; evaluates the residue |
| rx_fwd_valid | output | 1 | Forwarded bit qualifier |
| rx_fwd_bit | output | 1 | Forwarded bit, FCS included |
| rx_frame_ok | output | 1 | Frame passed the residue check |
| rx_crc_err | output | 1 | Frame failed the residue check or was too short |

## Verification
The bench sweeps every single-byte payload and a range of multi-byte lengths. A wrong tap, a shift in the wrong direction or a missing complement would give transmit FCS values that differ from the arithmetic ones. It would also give a well-known check string the wrong FCS. An empty frame and all-ones preset are tested so that a zero preset shows up as an FCS of 0xFFFF instead of 0x0000. Each looped-back frame is received once intact and once with a single flipped bit, so a comparison against the wrong residue or with inverted polarity flags a valid frame. Frames of 0 to 15 bits, statuses held across idle cycles, and `crc_en` toggled in mid-frame expose a missing length guard, status that drifts or fails to clear, and a mode read live instead of latched.

// File: rtl/fcs_pkg.sv
package fcs_pkg;
  localparam int unsigned FCS_W = 16;

  typedef enum logic [1:0] {
    LFSR_HOLD,
    LFSR_PRESET,
    LFSR_STEP,
    LFSR_SHIFT
  } lfsr_op_e;
endpackage

// File: rtl/fcs_lfsr.sv
module fcs_lfsr
  import fcs_pkg::*;
#(
  parameter int unsigned   W      = FCS_W,
  parameter logic [W-1:0]  POLY   = 16'h8408,
  parameter logic [W-1:0]  PRESET = '1
) (
  input  logic         clk,
  input  logic         rst,
  input  lfsr_op_e     op,
  input  logic         din,
  output logic [W-1:0] state
);
  logic [W-1:0] state_q;
  logic [W-1:0] step_v;
  logic         fb;

  assign fb = state_q[0] ^ din;

  // reflected form: shift toward bit 0, fold feedback into tap positions
  for (genvar i = 0; i < W; i++) begin : g_tap
    if (i == W - 1) begin : g_top
      assign step_v[i] = POLY[i] & fb;
    end else begin : g_mid
      assign step_v[i] = state_q[i+1] ^ (POLY[i] & fb);
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q <= PRESET;
    end else begin
      case (op)
        LFSR_PRESET: state_q <= PRESET;
        LFSR_STEP:   state_q <= step_v;
        LFSR_SHIFT:  state_q <= state_q >> 1;
        default:     state_q <= state_q;
      endcase
    end
  end

  assign state = state_q;
endmodule

// File: rtl/hdlc_fcs_tx.sv
module hdlc_fcs_tx
  import fcs_pkg::*;
#(
  parameter int unsigned   W      = FCS_W,
  parameter logic [W-1:0]  POLY   = 16'h8408,
  parameter logic [W-1:0]  PRESET = '1
) (
  input  logic clk,
  input  logic rst,
  input  logic crc_en,
  input  logic start,
  input  logic valid,
  input  logic bit_in,
  input  logic frame_end,
  output logic out_valid,
  output logic out_bit,
  output logic done
);
  localparam int unsigned CNT_W = $clog2(W);
  localparam logic [CNT_W-1:0] LAST = CNT_W'(W - 1);

  lfsr_op_e         op;
  logic [W-1:0]     crc;
  logic             mode_q, busy_q, arm_q;
  logic [CNT_W-1:0] cnt_q;
  logic             ov_q, ob_q, done_q;

  always_comb begin
    op = LFSR_HOLD;
    if (start)                          op = LFSR_PRESET;
    else if (busy_q)                    op = LFSR_SHIFT;
    else if (frame_end && mode_q)       op = LFSR_SHIFT;
    else if (valid)                     op = LFSR_STEP;
  end

  fcs_lfsr #(.W(W), .POLY(POLY), .PRESET(PRESET)) u_lfsr (
    .clk(clk), .rst(rst), .op(op), .din(bit_in), .state(crc)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      mode_q <= 1'b0;
      busy_q <= 1'b0;
      arm_q  <= 1'b0;
      cnt_q  <= '0;
      ov_q   <= 1'b0;
      ob_q   <= 1'b0;
      done_q <= 1'b0;
    end else begin
      ov_q   <= 1'b0;
      ob_q   <= 1'b0;
      arm_q  <= 1'b0;
      done_q <= arm_q;
      if (start) begin
        mode_q <= crc_en;
        busy_q <= 1'b0;
        cnt_q  <= '0;
      end else if (busy_q) begin
        ov_q  <= 1'b1;
        ob_q  <= ~crc[0];
        cnt_q <= cnt_q + 1'b1;
        if (cnt_q == LAST) begin
          busy_q <= 1'b0;
          arm_q  <= 1'b1;
        end
      end else if (frame_end) begin
        if (mode_q) begin
          ov_q   <= 1'b1;
          ob_q   <= ~crc[0];
          cnt_q  <= CNT_W'(1);
          busy_q <= 1'b1;
        end else begin
          done_q <= 1'b1;
        end
      end else if (valid) begin
        ov_q <= 1'b1;
        ob_q <= bit_in;
      end
    end
  end

  assign out_valid = ov_q;
  assign out_bit   = ob_q;
  assign done      = done_q;
endmodule

// File: rtl/hdlc_fcs_rx.sv
module hdlc_fcs_rx
  import fcs_pkg::*;
#(
  parameter int unsigned   W       = FCS_W,
  parameter logic [W-1:0]  POLY    = 16'h8408,
  parameter logic [W-1:0]  PRESET  = '1,
  parameter logic [W-1:0]  RESIDUE = 16'hF0B8
) (
  input  logic clk,
  input  logic rst,
  input  logic crc_en,
  input  logic start,
  input  logic valid,
  input  logic bit_in,
  input  logic frame_end,
  output logic fwd_valid,
  output logic fwd_bit,
  output logic frame_ok,
  output logic crc_err
);
  localparam int unsigned CNT_W = $clog2(W + 1);
  localparam logic [CNT_W-1:0] MIN_BITS = CNT_W'(W);

  lfsr_op_e         op;
  logic [W-1:0]     crc;
  logic             mode_q;
  logic [CNT_W-1:0] cnt_q;
  logic             fv_q, fb_q, ok_q, err_q;
  logic             good;

  always_comb begin
    op = LFSR_HOLD;
    if (start)      op = LFSR_PRESET;
    else if (valid) op = LFSR_STEP;
  end

  fcs_lfsr #(.W(W), .POLY(POLY), .PRESET(PRESET)) u_lfsr (
    .clk(clk), .rst(rst), .op(op), .din(bit_in), .state(crc)
  );

  assign good = (cnt_q == MIN_BITS) && (crc == RESIDUE);

  always_ff @(posedge clk) begin
    if (rst) begin
      mode_q <= 1'b0;
      cnt_q  <= '0;
      fv_q   <= 1'b0;
      fb_q   <= 1'b0;
      ok_q   <= 1'b0;
      err_q  <= 1'b0;
    end else begin
      fv_q <= 1'b0;
      fb_q <= 1'b0;
      if (start) begin
        mode_q <= crc_en;
        cnt_q  <= '0;
        ok_q   <= 1'b0;
        err_q  <= 1'b0;
      end else begin
        if (valid) begin
          fv_q <= 1'b1;
          fb_q <= bit_in;
          if (cnt_q != MIN_BITS) cnt_q <= cnt_q + 1'b1;
        end
        if (frame_end) begin
          ok_q  <= mode_q & good;
          err_q <= mode_q & ~good;
        end
      end
    end
  end

  assign fwd_valid = fv_q;
  assign fwd_bit   = fb_q;
  assign frame_ok  = ok_q;
  assign crc_err   = err_q;
endmodule

// File: rtl/hdlc_fcs_unit.sv
module hdlc_fcs_unit
  import fcs_pkg::*;
#(
  parameter int unsigned        W       = FCS_W,
  parameter logic [W-1:0]       POLY    = 16'h8408,
  parameter logic [W-1:0]       PRESET  = '1,
  parameter logic [W-1:0]       RESIDUE = 16'hF0B8
) (
  input  logic clk,
  input  logic rst,
  input  logic crc_en,
  input  logic tx_start,
  input  logic tx_valid,
  input  logic tx_bit,
  input  logic tx_end,
  output logic tx_out_valid,
  output logic tx_out_bit,
  output logic tx_done,
  input  logic rx_start,
  input  logic rx_valid,
  input  logic rx_bit,
  input  logic rx_end,
  output logic rx_fwd_valid,
  output logic rx_fwd_bit,
  output logic rx_frame_ok,
  output logic rx_crc_err
);
  hdlc_fcs_tx #(.W(W), .POLY(POLY), .PRESET(PRESET)) u_tx (
    .clk(clk), .rst(rst), .crc_en(crc_en),
    .start(tx_start), .valid(tx_valid), .bit_in(tx_bit), .frame_end(tx_end),
    .out_valid(tx_out_valid), .out_bit(tx_out_bit), .done(tx_done)
  );

  hdlc_fcs_rx #(.W(W), .POLY(POLY), .PRESET(PRESET), .RESIDUE(RESIDUE)) u_rx (
    .clk(clk), .rst(rst), .crc_en(crc_en),
    .start(rx_start), .valid(rx_valid), .bit_in(rx_bit), .frame_end(rx_end),
    .fwd_valid(rx_fwd_valid), .fwd_bit(rx_fwd_bit),
    .frame_ok(rx_frame_ok), .crc_err(rx_crc_err)
  );
endmodule

// File: rtl/hdlc_fcs_checker.sv
module hdlc_fcs_checker (
  input logic clk,
  input logic rst,
  input logic crc_en,
  input logic tx_start,
  input logic tx_done,
  input logic tx_out_valid,
  input logic rx_start,
  input logic rx_valid,
  input logic rx_bit,
  input logic rx_end,
  input logic rx_fwd_valid,
  input logic rx_fwd_bit,
  input logic rx_frame_ok,
  input logic rx_crc_err
);
  logic rx_mode_q;

  always_ff @(posedge clk) begin
    if (rst)           rx_mode_q <= 1'b0;
    else if (rx_start) rx_mode_q <= crc_en;
  end

  p_reset_quiet_r12: assert property (@(posedge clk)
    rst |=> !tx_out_valid && !tx_done && !rx_frame_ok && !rx_crc_err && !rx_fwd_valid);

  p_status_excl_r7: assert property (@(posedge clk) disable iff (rst)
    !(rx_frame_ok && rx_crc_err));

  p_fwd_bit_r6: assert property (@(posedge clk) disable iff (rst)
    (rx_valid && !rx_start) |=> (rx_fwd_valid && rx_fwd_bit == $past(rx_bit)));

  p_clear_r9: assert property (@(posedge clk) disable iff (rst)
    rx_start |=> (!rx_frame_ok && !rx_crc_err));

  p_hold_r9: assert property (@(posedge clk) disable iff (rst)
    (!rx_start && !rx_end) |=> ($stable(rx_frame_ok) && $stable(rx_crc_err)));

  p_bypass_r10: assert property (@(posedge clk) disable iff (rst)
    !rx_mode_q |-> (!rx_frame_ok && !rx_crc_err));

  p_done_pulse_r5: assert property (@(posedge clk) disable iff (rst)
    (tx_done && !tx_start) |=> !tx_done);
endmodule

bind hdlc_fcs_unit hdlc_fcs_checker u_chk (
  .clk(clk), .rst(rst), .crc_en(crc_en), .tx_start(tx_start),
  .tx_done(tx_done), .tx_out_valid(tx_out_valid),
  .rx_start(rx_start), .rx_valid(rx_valid), .rx_bit(rx_bit), .rx_end(rx_end),
  .rx_fwd_valid(rx_fwd_valid), .rx_fwd_bit(rx_fwd_bit),
  .rx_frame_ok(rx_frame_ok), .rx_crc_err(rx_crc_err)
);

// File: tb/sim_hdlc_fcs_unit.sv
`timescale 1ns/1ps
module sim_hdlc_fcs_unit;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic crc_en = 1'b1;
  logic tx_start = 0, tx_valid = 0, tx_bit = 0, tx_end = 0;
  logic rx_start = 0, rx_valid = 0, rx_bit = 0, rx_end = 0;
  logic tx_out_valid, tx_out_bit, tx_done;
  logic rx_fwd_valid, rx_fwd_bit, rx_frame_ok, rx_crc_err;

  int n_chk = 0;
  int n_bad = 0;

  always #2 clk = ~clk;

  hdlc_fcs_unit u0 (
    .clk(clk), .rst(rst), .crc_en(crc_en),
    .tx_start(tx_start), .tx_valid(tx_valid), .tx_bit(tx_bit), .tx_end(tx_end),
    .tx_out_valid(tx_out_valid), .tx_out_bit(tx_out_bit), .tx_done(tx_done),
    .rx_start(rx_start), .rx_valid(rx_valid), .rx_bit(rx_bit), .rx_end(rx_end),
    .rx_fwd_valid(rx_fwd_valid), .rx_fwd_bit(rx_fwd_bit),
    .rx_frame_ok(rx_frame_ok), .rx_crc_err(rx_crc_err)
  );

  task automatic chk(input bit cond, input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!cond) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h at %0t", tag, act, exp, $time);
    end
  endtask

  // expected FCS from the requirements: reflected 0x8408, preset ones, complement
  function automatic logic [15:0] ref_fcs(input logic [255:0] v, input int n);
    logic [15:0] c = 16'hFFFF;
    for (int i = 0; i < n; i++) begin
      logic f = c[0] ^ v[i];
      c = c >> 1;
      if (f) c = c ^ 16'h8408;
    end
    return ~c;
  endfunction

  task automatic tx_frame(input logic [255:0] v, input int n, input bit m0, input bit m1,
                          output logic [15:0] fcs);
    fcs = '0;
    @(negedge clk); crc_en = m0; tx_start = 1;
    @(negedge clk); tx_start = 0; crc_en = m1;
    for (int i = 0; i < n; i++) begin
      tx_valid = 1; tx_bit = v[i];
      @(negedge clk);
      chk(tx_out_valid && tx_out_bit == v[i], "R3 data pass", {tx_out_valid, tx_out_bit}, {1'b1, v[i]});
    end
    tx_valid = 0; tx_end = 1;
    @(negedge clk); tx_end = 0;
    if (m0) begin
      for (int k = 0; k < 16; k++) begin
        chk(tx_out_valid == 1'b1, "R4 fcs valid", tx_out_valid, 1);
        chk(tx_done == 1'b0, "R5 early done", tx_done, 0);
        fcs[k] = tx_out_bit;
        @(negedge clk);
      end
      chk(tx_done && !tx_out_valid, "R5 done after fcs", {tx_done, tx_out_valid}, 2'b10);
    end else begin
      chk(tx_done && !tx_out_valid, "R10 no fcs, done", {tx_done, tx_out_valid}, 2'b10);
    end
    @(negedge clk);
    chk(!tx_done && !tx_out_valid, "R5 done pulse", {tx_done, tx_out_valid}, 0);
  endtask

  task automatic rx_frame(input logic [255:0] v, input int n, input bit m0, input bit m1,
                          output logic ok, output logic err);
    @(negedge clk); crc_en = m0; rx_start = 1;
    @(negedge clk); rx_start = 0; crc_en = m1;
    chk(!rx_frame_ok && !rx_crc_err, "R9 cleared", {rx_frame_ok, rx_crc_err}, 0);
    for (int i = 0; i < n; i++) begin
      rx_valid = 1; rx_bit = v[i];
      @(negedge clk);
      chk(rx_fwd_valid && rx_fwd_bit == v[i], "R6 forward", {rx_fwd_valid, rx_fwd_bit}, {1'b1, v[i]});
    end
    rx_valid = 0; rx_end = 1;
    @(negedge clk); rx_end = 0;
    ok = rx_frame_ok; err = rx_crc_err;
  endtask

  initial begin
    #(4 * 200000);
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual running expected finished");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    logic [255:0] v;
    logic [15:0] f, e;
    logic ok, err;
    repeat (3) @(negedge clk);
    rst = 0;
    @(negedge clk);
    chk(!tx_out_valid && !tx_done && !rx_fwd_valid && !rx_frame_ok && !rx_crc_err,
        "R12 reset", {tx_out_valid, tx_done, rx_fwd_valid, rx_frame_ok, rx_crc_err}, 0);

    // R1 empty frame
    v = '0;
    tx_frame(v, 0, 1, 1, f);
    chk(f == 16'h0000, "R1 empty fcs", f, 16'h0000);

    // R2 check string "123456789"
    for (int b = 0; b < 9; b++) v[b*8 +: 8] = 8'h31 + 8'(b);
    tx_frame(v, 72, 1, 1, f);
    chk(f == 16'h906E, "R2 check string", f, 16'h906E);
    v[72 +: 16] = f;
    rx_frame(v, 88, 1, 1, ok, err);
    chk(ok && !err, "R7 check string rx", {ok, err}, 2'b10);

    // sweep every single-byte payload: tx FCS, rx intact, rx one bit flipped
    for (int d = 0; d < 256; d++) begin
      v = '0; v[7:0] = 8'(d);
      tx_frame(v, 8, 1, 1, f);
      e = ref_fcs(v, 8);
      chk(f == e, "R4 byte fcs", f, e);
      v[8 +: 16] = f;
      rx_frame(v, 24, 1, 1, ok, err);
      chk(ok && !err, "R7 good frame", {ok, err}, 2'b10);
      v[d % 24] = ~v[d % 24];
      rx_frame(v, 24, 1, 1, ok, err);
      chk(!ok && err, "R7 bad frame", {ok, err}, 2'b01);
    end

    // multi-byte lengths
    for (int len = 2; len <= 16; len++) begin
      for (int b = 0; b < len; b++) v[b*8 +: 8] = 8'(b * 37 + len * 11);
      tx_frame(v, len * 8, 1, 1, f);
      e = ref_fcs(v, len * 8);
      chk(f == e, "R4 multi fcs", f, e);
      v[len*8 +: 16] = f;
      rx_frame(v, len * 8 + 16, 1, 1, ok, err);
      chk(ok && !err, "R7 multi rx", {ok, err}, 2'b10);
    end

    // R8 short frames, including a 15-bit tail of a valid frame
    for (int n = 0; n < 16; n++) begin
      v = 256'h0F47_A5C3;
      rx_frame(v, n, 1, 1, ok, err);
      chk(!ok && err, "R8 short frame", {ok, err}, 2'b01);
    end

    // R9 hold across idle, then clear on next start
    v = '0; v[7:0] = 8'h5A; v[8 +: 16] = ref_fcs(v, 8);
    rx_frame(v, 24, 1, 1, ok, err);
    repeat (10) @(negedge clk);
    chk(rx_frame_ok && !rx_crc_err, "R9 held", {rx_frame_ok, rx_crc_err}, 2'b10);
    rx_frame(v, 0, 1, 1, ok, err);
    chk(!ok && err, "R9 new result", {ok, err}, 2'b01);

    // R10 no-CRC mode
    v = '0; v[7:0] = 8'hC3;
    tx_frame(v, 8, 0, 0, f);
    v[8 +: 16] = ref_fcs(v, 8);
    rx_frame(v, 24, 0, 0, ok, err);
    chk(!ok && !err, "R10 rx bypass good", {ok, err}, 0);
    v[3] = ~v[3];
    rx_frame(v, 24, 0, 0, ok, err);
    chk(!ok && !err, "R10 rx bypass bad", {ok, err}, 0);
    repeat (3) @(negedge clk);
    chk(!rx_frame_ok && !rx_crc_err, "R10 stays low", {rx_frame_ok, rx_crc_err}, 0);

    // R11 mode latched on start
    v = '0; v[7:0] = 8'h81;
    tx_frame(v, 8, 1, 0, f);
    e = ref_fcs(v, 8);
    chk(f == e, "R11 tx latched crc", f, e);
    tx_frame(v, 8, 0, 1, f);
    v[8 +: 16] = e;
    rx_frame(v, 24, 1, 0, ok, err);
    chk(ok && !err, "R11 rx latched crc", {ok, err}, 2'b10);
    rx_frame(v, 24, 0, 1, ok, err);
    chk(!ok && !err, "R11 rx latched bypass", {ok, err}, 0);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule